// File: doc/BRIEF.md
# Double-Buffered Infoframe Packet Store

This block keeps up to fifteen generic video info packets for a display transmitter, for example auxiliary video information or secondary-data packets on a DisplayPort link. Each packet slot is nine 32-bit dwords long: a header dword followed by eight payload dwords. Software loads a flat dword index once and then streams dwords through a single write port. The index steps forward by one after every accepted write, so one slot, or several adjacent slots, can be filled without reloading it.

Every slot has two copies: a shadow copy that software writes and an active copy that the transmitter reads. Software marks a slot for update by setting its request bit. At the next frame-boundary pulse, if the update lock input is low, every pending slot copies its shadow into its active copy in the same clock, and its request bit clears. The transmitter fetches active dwords through a registered read port. A sticky flag records any cycle in which a hardware read and a software write happen together. Software can poll this flag before it writes and clear it with a dedicated input.

Top module: `infoframe_store`

## Requirements
- R1: After reset, all request bits read 0, the collision flag reads 0, the read data output is 0, and every dword in both the shadow and the active copies is 0.
- R2: Slot n occupies flat dword indices 9n to 9n+8. Index 9n holds the header, with header byte k in bits 8k+7:8k. After the index is loaded, each accepted write stores its data at the current index and then advances the index by one, crossing slot boundaries.
- R3: A write issued while the index is at 135 or higher changes no dword, and the index stays where it is.
- R4: Shadow writes are not visible on the read port until that slot commits.
- R5: Pulsing a slot's bit on the request-set input makes that bit read 1 from the next cycle until the slot commits. Request bits of other slots are not affected.
- R6: On a clock with the frame pulse high and the lock low, every pending slot copies all nine shadow dwords into its active copy, and every pending bit clears. Slots that are not pending keep their active contents.
- R7: While the lock is high, frame pulses commit nothing, and pending bits stay set.
- R8: A request bit set in the same cycle as a committing frame pulse does not commit on that pulse. It stays pending for the next one.
- R9: A read request returns the active dword on the read data output one clock later. A slot number of 15 or more, or an offset of 9 or more, returns 0. The output holds its value when no read is requested.
- R10: A clock with both a hardware read request and a software write sets the collision flag, and the flag stays set until it is cleared. A write alone or a read alone does not set it.
- R11: Pulsing the clear input resets the collision flag on the next edge. If a collision happens in the same cycle, the flag is set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idx_load | input | 1 | Loads idx_value into the write index |
| idx_value | input | 8 | Flat dword index to load |
| wr_en | input | 1 | Software write strobe on the data port |
| wr_data | input | 32 | Dword to write into the shadow copy |
| upd_req_set | input | 15 | One bit per slot; a 1 marks that slot pending |
| upd_pending | output | 15 | Pending request bits, one per slot |
| frame_pulse | input | 1 | Frame-boundary strobe |
| update_lock | input | 1 | Blocks commits while high |
| rd_en | input | 1 | Hardware read request |
| rd_slot | input | 4 | Slot number to read |
| rd_offset | input | 4 | Dword offset within the slot, 0 to 8 |
| rd_data | output | 32 | Active dword, registered |
| coll_clr | input | 1 | Clears the collision flag |
| coll_flag | output | 1 | Sticky collision flag |

## Verification
The request bits, the collision flag and the write index change on the first rising edge after their stimulus. Read data arrives on the first edge after the read request. A commit is visible on the read port to any read issued after the committing edge. The bench drives every input at a falling edge and samples at the next falling edge, so each result is observed exactly one edge after its stimulus. Commit results are confirmed by full sweeps over all 135 active dwords, compared against an expected image that the bench computes arithmetically.

// File: rtl/infoframe_pkg.sv
package infoframe_pkg;
   localparam int unsigned DWORD_BITS = 32;
   typedef logic [DWORD_BITS-1:0] dword_t;
endpackage

// File: rtl/ifs_index_ctrl.sv
module ifs_index_ctrl
   import infoframe_pkg::*;
#(
   parameter int unsigned NUM_SLOTS      = 15,
   parameter int unsigned WORDS_PER_SLOT = 9,
   parameter int unsigned IDX_W          = 8,
   parameter int unsigned SLOT_W         = 4,
   parameter int unsigned OFF_W          = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_load,
   input  logic [IDX_W-1:0]  idx_value,
   input  logic              wr_en,
   output logic [IDX_W-1:0]  ptr,
   output logic              wr_accept,
   output logic [SLOT_W-1:0] slot_q,
   output logic [OFF_W-1:0]  word_q
);
   localparam int unsigned TOTAL = NUM_SLOTS * WORDS_PER_SLOT;

   assign wr_accept = wr_en && (ptr < IDX_W'(TOTAL));

   // slot and word counters run beside the flat pointer, so no divider sits in the write path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr    <= '0;
         slot_q <= '0;
         word_q <= '0;
      end else if (idx_load) begin
         ptr    <= idx_value;
         slot_q <= SLOT_W'(idx_value / IDX_W'(WORDS_PER_SLOT));
         word_q <= OFF_W'(idx_value % IDX_W'(WORDS_PER_SLOT));
      end else if (wr_accept) begin
         ptr <= ptr + IDX_W'(1);
         if (word_q == OFF_W'(WORDS_PER_SLOT - 1)) begin
            word_q <= '0;
            slot_q <= slot_q + SLOT_W'(1);
         end else begin
            word_q <= word_q + OFF_W'(1);
         end
      end
   end
endmodule

// File: rtl/ifs_slot_buf.sv
module ifs_slot_buf
   import infoframe_pkg::*;
#(
   parameter int unsigned WORDS_PER_SLOT = 9,
   parameter int unsigned OFF_W          = 4
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        wr_hit,
   input  logic [OFF_W-1:0]                            wr_word,
   input  dword_t                                      wr_data,
   input  logic                                        req_set,
   input  logic                                        commit,
   output logic                                        pending,
   output logic [WORDS_PER_SLOT-1:0][DWORD_BITS-1:0]   active_words
);
   logic [WORDS_PER_SLOT-1:0][DWORD_BITS-1:0] shadow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow       <= '0;
         active_words <= '0;
         pending      <= 1'b0;
      end else begin
         if (wr_hit) shadow[wr_word] <= wr_data;
         if (commit && pending) active_words <= shadow;
         // a request arriving on the commit edge survives for the next frame
         pending <= commit ? req_set : (pending | req_set);
      end
   end
endmodule

// File: rtl/ifs_collision.sv
module ifs_collision (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_rd,
   input  logic sw_wr,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flag <= 1'b0;
      else if (hw_rd && sw_wr) flag <= 1'b1;
      else if (clr)            flag <= 1'b0;
   end
endmodule

// File: rtl/infoframe_store.sv
module infoframe_store
   import infoframe_pkg::*;
#(
   parameter int unsigned NUM_SLOTS      = 15,
   parameter int unsigned WORDS_PER_SLOT = 9,
   parameter int unsigned IDX_W          = $clog2(NUM_SLOTS * WORDS_PER_SLOT + 1),
   parameter int unsigned SLOT_W         = $clog2(NUM_SLOTS + 1),
   parameter int unsigned OFF_W          = $clog2(WORDS_PER_SLOT + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  idx_load,
   input  logic [IDX_W-1:0]      idx_value,
   input  logic                  wr_en,
   input  logic [DWORD_BITS-1:0] wr_data,
   input  logic [NUM_SLOTS-1:0]  upd_req_set,
   output logic [NUM_SLOTS-1:0]  upd_pending,
   input  logic                  frame_pulse,
   input  logic                  update_lock,
   input  logic                  rd_en,
   input  logic [SLOT_W-1:0]     rd_slot,
   input  logic [OFF_W-1:0]      rd_offset,
   output logic [DWORD_BITS-1:0] rd_data,
   input  logic                  coll_clr,
   output logic                  coll_flag
);
   localparam int unsigned TOTAL = NUM_SLOTS * WORDS_PER_SLOT;

   generate
      if (NUM_SLOTS < 1 || WORDS_PER_SLOT < 2) begin : g_bad_geometry
         $error("infoframe_store: need at least one slot and two dwords per slot");
      end
      if ((1 << IDX_W) <= TOTAL) begin : g_bad_idx
         $error("infoframe_store: IDX_W cannot express the out-of-range index");
      end
      if ((1 << SLOT_W) <= NUM_SLOTS || (1 << OFF_W) <= WORDS_PER_SLOT) begin : g_bad_sel
         $error("infoframe_store: SLOT_W or OFF_W too narrow");
      end
   endgenerate

   logic [IDX_W-1:0]  wr_ptr;
   logic              wr_accept;
   logic [SLOT_W-1:0] wr_slot;
   logic [OFF_W-1:0]  wr_word;
   logic              commit;

   assign commit = frame_pulse && !update_lock;

   ifs_index_ctrl #(
      .NUM_SLOTS(NUM_SLOTS), .WORDS_PER_SLOT(WORDS_PER_SLOT),
      .IDX_W(IDX_W), .SLOT_W(SLOT_W), .OFF_W(OFF_W)
   ) u_idx (
      .clk(clk), .rst_n(rst_n), .idx_load(idx_load), .idx_value(idx_value),
      .wr_en(wr_en), .ptr(wr_ptr), .wr_accept(wr_accept),
      .slot_q(wr_slot), .word_q(wr_word)
   );

   logic [WORDS_PER_SLOT-1:0][DWORD_BITS-1:0] act [NUM_SLOTS];

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         logic hit;
         assign hit = wr_accept && (wr_slot == SLOT_W'(s));
         ifs_slot_buf #(
            .WORDS_PER_SLOT(WORDS_PER_SLOT), .OFF_W(OFF_W)
         ) u_buf (
            .clk(clk), .rst_n(rst_n), .wr_hit(hit), .wr_word(wr_word),
            .wr_data(wr_data), .req_set(upd_req_set[s]), .commit(commit),
            .pending(upd_pending[s]), .active_words(act[s])
         );
      end
   endgenerate

   ifs_collision u_coll (
      .clk(clk), .rst_n(rst_n), .hw_rd(rd_en), .sw_wr(wr_en),
      .clr(coll_clr), .flag(coll_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         if (rd_slot < SLOT_W'(NUM_SLOTS) && rd_offset < OFF_W'(WORDS_PER_SLOT))
            rd_data <= act[rd_slot][rd_offset];
         else
            rd_data <= '0;
      end
   end
endmodule

// File: rtl/infoframe_store_chk.sv
module infoframe_store_chk #(
   parameter int unsigned NUM_SLOTS = 15,
   parameter int unsigned IDX_W     = 8,
   parameter int unsigned TOTAL     = 135
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 idx_load,
   input logic [IDX_W-1:0]     idx_value,
   input logic                 wr_en,
   input logic                 rd_en,
   input logic                 coll_clr,
   input logic                 coll_flag,
   input logic                 frame_pulse,
   input logic                 update_lock,
   input logic [NUM_SLOTS-1:0] upd_req_set,
   input logic [NUM_SLOTS-1:0] upd_pending,
   input logic [31:0]          rd_data,
   input logic [IDX_W-1:0]     ptr
);
   p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !idx_load && ptr < IDX_W'(TOTAL)) |=> ptr == $past(ptr) + IDX_W'(1));

   p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      idx_load |=> ptr == $past(idx_value));

   p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !idx_load && ptr >= IDX_W'(TOTAL)) |=> $stable(ptr));

   p_pend_accum_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_pulse |=> upd_pending == ($past(upd_pending) | $past(upd_req_set)));

   p_commit_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_pulse && !update_lock) |=> upd_pending == $past(upd_req_set));

   p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_pulse && update_lock) |=> upd_pending == ($past(upd_pending) | $past(upd_req_set)));

   p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   p_coll_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_en) |=> coll_flag);

   p_coll_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (coll_flag && !coll_clr) |=> coll_flag);

   p_coll_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (coll_clr && !(rd_en && wr_en)) |=> !coll_flag);
endmodule

bind infoframe_store infoframe_store_chk #(
   .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W), .TOTAL(TOTAL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .idx_load(idx_load), .idx_value(idx_value),
   .wr_en(wr_en), .rd_en(rd_en), .coll_clr(coll_clr), .coll_flag(coll_flag),
   .frame_pulse(frame_pulse), .update_lock(update_lock),
   .upd_req_set(upd_req_set), .upd_pending(upd_pending),
   .rd_data(rd_data), .ptr(wr_ptr)
);

// File: tb/sim_infoframe_store.sv
module sim_infoframe_store;
   localparam int NS  = 15;
   localparam int WPS = 9;
   localparam int TOT = NS * WPS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          idx_load = 1'b0;
   logic [7:0]    idx_value = '0;
   logic          wr_en = 1'b0;
   logic [31:0]   wr_data = '0;
   logic [NS-1:0] upd_req_set = '0;
   logic [NS-1:0] upd_pending;
   logic          frame_pulse = 1'b0;
   logic          update_lock = 1'b0;
   logic          rd_en = 1'b0;
   logic [3:0]    rd_slot = '0;
   logic [3:0]    rd_offset = '0;
   logic [31:0]   rd_data;
   logic          coll_clr = 1'b0;
   logic          coll_flag;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [31:0] exp_shadow [TOT];
   logic [31:0] exp_active [TOT];
   logic [31:0] got;

   always #5 clk = ~clk;

   infoframe_store u0 (
      .clk(clk), .rst_n(rst_n), .idx_load(idx_load), .idx_value(idx_value),
      .wr_en(wr_en), .wr_data(wr_data), .upd_req_set(upd_req_set),
      .upd_pending(upd_pending), .frame_pulse(frame_pulse),
      .update_lock(update_lock), .rd_en(rd_en), .rd_slot(rd_slot),
      .rd_offset(rd_offset), .rd_data(rd_data), .coll_clr(coll_clr),
      .coll_flag(coll_flag)
   );

   function automatic logic [31:0] pat(input int i, input logic [31:0] seed);
      return (32'(i) * 32'h9E37_79B1) ^ seed;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_idx(input int v);
      @(negedge clk); idx_load = 1'b1; idx_value = 8'(v);
      @(negedge clk); idx_load = 1'b0;
   endtask

   // model: accepted writes land at the current index; out-of-range writes do nothing
   int m_ptr = 0;
   task automatic wr_word(input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
      if (m_ptr < TOT) begin
         exp_shadow[m_ptr] = d;
         m_ptr++;
      end
   endtask

   task automatic rd_word(input int s, input int o, output logic [31:0] d);
      @(negedge clk); rd_en = 1'b1; rd_slot = 4'(s); rd_offset = 4'(o);
      @(negedge clk); rd_en = 1'b0; d = rd_data;
   endtask

   task automatic pulse(input logic [NS-1:0] req, input logic lock);
      @(negedge clk); frame_pulse = 1'b1; update_lock = lock; upd_req_set = req;
      @(negedge clk); frame_pulse = 1'b0; update_lock = 1'b0; upd_req_set = '0;
   endtask

   task automatic request(input logic [NS-1:0] req);
      @(negedge clk); upd_req_set = req;
      @(negedge clk); upd_req_set = '0;
   endtask

   task automatic commit_model(input logic [NS-1:0] pend);
      for (int s = 0; s < NS; s++)
         if (pend[s])
            for (int o = 0; o < WPS; o++) exp_active[s*WPS+o] = exp_shadow[s*WPS+o];
   endtask

   task automatic sweep(input string req);
      logic [31:0] d;
      for (int i = 0; i < TOT; i++) begin
         rd_word(i / WPS, i % WPS, d);
         chk(req, d, exp_active[i]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < TOT; i++) begin exp_shadow[i] = '0; exp_active[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 pending", 32'(upd_pending), 32'h0);
      chk("R1 coll", 32'(coll_flag), 32'h0);
      chk("R1 rd_data", rd_data, 32'h0);
      sweep("R1 active");

      // R2: fill every slot through one index load
      load_idx(0); m_ptr = 0;
      for (int i = 0; i < TOT; i++) wr_word(pat(i, 32'h1234_5678));
      // R3: two writes past the end
      wr_word(32'hDEAD_0001); wr_word(32'hDEAD_0002);
      // R4: nothing visible before commit
      rd_word(0, 0, got); chk("R4 slot0 hdr", got, 32'h0);
      rd_word(14, 8, got); chk("R4 slot14 last", got, 32'h0);

      // R5: request every slot
      request({NS{1'b1}});
      chk("R5 pending all", 32'(upd_pending), 32'h7FFF);
      // R7: locked pulse
      pulse('0, 1'b1);
      chk("R7 pending kept", 32'(upd_pending), 32'h7FFF);
      rd_word(3, 0, got); chk("R7 no commit", got, 32'h0);
      // R6: unlocked pulse commits every pending slot at once
      pulse('0, 1'b0);
      chk("R6 pending clear", 32'(upd_pending), 32'h0);
      commit_model({NS{1'b1}});
      sweep("R2 R3 R6 full image");

      // R6/R5: selective commit of slot 5 while slot 2 is also rewritten
      load_idx(5*WPS); m_ptr = 5*WPS;
      wr_word(32'h4433_2211);
      for (int o = 1; o < WPS; o++) wr_word(pat(o, 32'h0BAD_F00D));
      load_idx(2*WPS); m_ptr = 2*WPS;
      for (int o = 0; o < WPS; o++) wr_word(pat(o, 32'h5555_AAAA));
      request(15'h0020);
      chk("R5 only slot5", 32'(upd_pending), 32'h0020);
      pulse('0, 1'b0);
      commit_model(15'h0020);
      rd_word(5, 0, got); chk("R2 header slot5", got, 32'h4433_2211);
      rd_word(2, 0, got); chk("R6 slot2 unchanged", got, exp_active[18]);

      // R8: request set on the commit edge waits
      pulse(15'h0004, 1'b0);
      chk("R8 still pending", 32'(upd_pending), 32'h0004);
      rd_word(2, 4, got); chk("R8 slot2 old", got, exp_active[22]);
      pulse('0, 1'b0);
      commit_model(15'h0004);
      chk("R8 pending cleared", 32'(upd_pending), 32'h0);
      sweep("R6 R8 image");

      // R3: loaded out-of-range index writes nothing
      load_idx(200); m_ptr = 200;
      wr_word(32'hFFFF_FFFF); wr_word(32'hEEEE_EEEE);
      request({NS{1'b1}});
      pulse('0, 1'b0);
      commit_model({NS{1'b1}});
      sweep("R3 image after ignored writes");

      // R9: out-of-range reads
      rd_word(15, 0, got); chk("R9 slot15", got, 32'h0);
      rd_word(0, 9, got);  chk("R9 offset9", got, 32'h0);
      rd_word(1, 1, got);  chk("R9 normal", got, exp_active[10]);

      // R10: collisions
      load_idx(200); m_ptr = 200;
      wr_word(32'h1); chk("R10 write alone", 32'(coll_flag), 32'h0);
      rd_word(0, 0, got); chk("R10 read alone", 32'(coll_flag), 32'h0);
      @(negedge clk); wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
      chk("R10 set", 32'(coll_flag), 32'h1);
      repeat (3) @(negedge clk);
      chk("R10 sticky", 32'(coll_flag), 32'h1);
      // R11: clear, then clear against a collision
      @(negedge clk); coll_clr = 1'b1;
      @(negedge clk); coll_clr = 1'b0;
      chk("R11 cleared", 32'(coll_flag), 32'h0);
      @(negedge clk); coll_clr = 1'b1; wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk); coll_clr = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      chk("R11 set wins", 32'(coll_flag), 32'h1);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule